// File: doc/BRIEF.md
# Write FIFO Flush Controller

This block runs in the memory-controller clock domain. It decides when the streaming write FIFO in front of a memory driver is drained and its contents thrown away, and when incoming data is kept for the next write access. It produces a single registered level, `flush_en`, for a downstream stream flusher. The block only makes the decision. The FIFO, the driver, the flusher datapath and any clock crossing are outside it.

After reset the FIFO is drained by default. Draining continues until software starts a write access. Even then it does not stop at once. It stops at the next stream boundary of a kind chosen by a parameter: any valid beat, a start-of-packet, or a sync marker. Sync can arrive on the stream's sop bit, and a parameter selects that convention. Between accesses, a flush request drains the FIFO again. A request made during an access is ignored.

Top module: `wr_flush_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset, `flush_en` is 1. It stays 1 while no write access has been started, whatever the stream inputs do.
- R2: A read access (`acc_en`=1, `acc_wr`=0) never ends an active flush, and `flush_en` stays 1.
- R3: A write access (`acc_en`=1, `acc_wr`=1) during a flush arms the release, but `flush_en` stays 1 after that cycle. Release happens only on a boundary seen in a later cycle.
- R4: With mode `REL_VALID`, an armed flush ends on the first cycle with `st_valid`=1. `flush_en` is 0 from the next cycle.
- R5: With mode `REL_SOP`, an armed flush ends only on a cycle with `st_valid`=1 and `st_sop`=1. A valid beat without sop, or sop without valid, leaves `flush_en` at 1.
- R6: With mode `REL_SYNC` and `SYNC_ON_SOP`=1, the sync marker is taken from `st_sop`. An armed flush ends on `st_valid`=1 with `st_sop`=1, and `st_sync` is ignored.
- R7: With mode `REL_SYNC` and `SYNC_ON_SOP`=0, an armed flush ends on `st_valid`=1 with `st_sync`=1, and `st_sop` is ignored.
- R8: While not flushing, a `flush_req` pulse with `acc_done`=1 and `acc_en`=0 sets `flush_en` to 1 from the next cycle.
- R9: While not flushing, a `flush_req` pulse with `acc_done`=0 is ignored, and `flush_en` stays 0.
- R10: When `flush_req` and `acc_en` coincide while not flushing, the access wins and `flush_en` stays 0.
- R11: `flush_en` is a register output. An active flush never drops in a cycle that follows a cycle without a release boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | One-cycle access start pulse |
| acc_wr | input | 1 | Access direction, 1 = write, 0 = read |
| acc_done | input | 1 | Driver idle flag, high between accesses |
| flush_req | input | 1 | One-cycle flush request pulse |
| st_valid | input | 1 | Write stream beat valid |
| st_sop | input | 1 | Write stream start-of-packet (carries sync when `SYNC_ON_SOP`=1) |
| st_sync | input | 1 | Write stream sync marker on its own wire |
| flush_en | output | 1 | Registered flush-enable level to the flusher |

## Verification
The assertions assume that `acc_en` and `flush_req` are single-cycle pulses. They also assume that `acc_done` follows the driver, so it is low for the duration of an access and high between accesses. The stimulus drives every pulse for exactly one clock. It lowers `acc_done` whenever it models a running access and raises it only when it models the gap between accesses. Four copies of the block, one for each release variant, share the same inputs, so each boundary pattern is judged against every mode in the same cycle.

// File: rtl/wfc_pkg.sv
package wfc_pkg;

   // Stream boundary on which an armed flush is released
   typedef enum logic [1:0] {
      REL_VALID = 2'd0,
      REL_SOP   = 2'd1,
      REL_SYNC  = 2'd2
   } rel_mode_e;

   typedef enum logic [1:0] {
      S_FLUSH = 2'd0,   // draining, no write access requested yet
      S_ARMED = 2'd1,   // draining, write requested, waiting for boundary
      S_FILL  = 2'd2    // keeping data for the driver
   } flush_state_e;

endpackage

// File: rtl/wfc_boundary.sv
module wfc_boundary
   import wfc_pkg::*;
#(
   parameter rel_mode_e MODE        = REL_SYNC,
   parameter bit        SYNC_ON_SOP = 1'b1
) (
   input  logic st_valid,
   input  logic st_sop,
   input  logic st_sync,
   output logic boundary
);

   // Sync marker and packet start, after applying the sop-carries-sync rule
   logic eff_sync;
   logic eff_sop;

   if (SYNC_ON_SOP) begin : g_sync_on_sop
      assign eff_sync = st_sop;
      assign eff_sop  = 1'b0;
      logic unused_sync;
      assign unused_sync = st_sync;
   end else begin : g_sync_wire
      assign eff_sync = st_sync;
      assign eff_sop  = st_sop;
   end

   if (MODE == REL_VALID) begin : g_rel_valid
      assign boundary = st_valid;
      logic unused_marks;
      assign unused_marks = eff_sop ^ eff_sync;
   end else if (MODE == REL_SOP) begin : g_rel_sop
      // sop mode sees the raw sop bit; no sync remapping applies here
      assign boundary = st_valid & st_sop;
      logic unused_marks;
      assign unused_marks = eff_sop ^ eff_sync;
   end else if (MODE == REL_SYNC) begin : g_rel_sync
      assign boundary = st_valid & eff_sync;
      logic unused_marks;
      assign unused_marks = eff_sop;
   end else begin : g_rel_bad
      $error("wfc_boundary: unsupported release mode");
      assign boundary = 1'b0;
   end

endmodule

// File: rtl/wfc_fsm.sv
module wfc_fsm
   import wfc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic acc_en,
   input  logic acc_wr,
   input  logic acc_done,
   input  logic flush_req,
   input  logic boundary,
   output logic flush_en
);

   flush_state_e st_q, st_nx;
   logic         flush_q;

   always_comb begin
      st_nx = st_q;
      case (st_q)
         S_FLUSH: if (acc_en && acc_wr) st_nx = S_ARMED;
         S_ARMED: if (boundary) st_nx = S_FILL;
         S_FILL:  if (flush_req && acc_done && !acc_en) st_nx = S_FLUSH;
         default: st_nx = S_FLUSH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= S_FLUSH;
         flush_q <= 1'b1;
      end else begin
         st_q    <= st_nx;
         flush_q <= (st_nx != S_FILL);
      end
   end

   assign flush_en = flush_q;

   // R1: the flush is active straight after reset
   a_r1_flush_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> flush_en);

   // R2: a read start while draining keeps the flush
   a_r2_read_keeps_flush: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_FLUSH && acc_en && !acc_wr) |=> flush_en);

   // R3: while not yet armed the flush cannot end
   a_r3_unarmed_holds: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_FLUSH) |=> flush_en);

   // R8: accepted request
   a_r8_req_accepted: assert property (@(posedge clk) disable iff (rst)
      (!flush_en && flush_req && acc_done && !acc_en) |=> flush_en);

   // R9: request during an access is ignored
   a_r9_req_busy_ignored: assert property (@(posedge clk) disable iff (rst)
      (!flush_en && flush_req && !acc_done) |=> !flush_en);

   // R10: access start beats a simultaneous request
   a_r10_en_priority: assert property (@(posedge clk) disable iff (rst)
      (!flush_en && flush_req && acc_en) |=> !flush_en);

   // R11: no release without a boundary
   a_r11_no_boundary_holds: assert property (@(posedge clk) disable iff (rst)
      (flush_en && !boundary) |=> flush_en);

endmodule

// File: rtl/wr_flush_ctrl.sv
module wr_flush_ctrl
   import wfc_pkg::*;
#(
   parameter rel_mode_e MODE        = REL_SYNC,
   parameter bit        SYNC_ON_SOP = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic acc_en,
   input  logic acc_wr,
   input  logic acc_done,
   input  logic flush_req,
   input  logic st_valid,
   input  logic st_sop,
   input  logic st_sync,
   output logic flush_en
);

   logic boundary;

   wfc_boundary #(
      .MODE        (MODE),
      .SYNC_ON_SOP (SYNC_ON_SOP)
   ) u_boundary (
      .st_valid (st_valid),
      .st_sop   (st_sop),
      .st_sync  (st_sync),
      .boundary (boundary)
   );

   wfc_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .acc_en    (acc_en),
      .acc_wr    (acc_wr),
      .acc_done  (acc_done),
      .flush_req (flush_req),
      .boundary  (boundary),
      .flush_en  (flush_en)
   );

endmodule

// File: tb/test_wr_flush_ctrl.sv
`timescale 1ns/1ps
module test_wr_flush_ctrl;
   import wfc_pkg::*;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic acc_en = 1'b0, acc_wr = 1'b0, acc_done = 1'b1, flush_req = 1'b0;
   logic st_valid = 1'b0, st_sop = 1'b0, st_sync = 1'b0;
   logic fe_sync, fe_val, fe_sop, fe_syw;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   wr_flush_ctrl #(.MODE(REL_SYNC), .SYNC_ON_SOP(1'b1)) i_wr_flush_ctrl (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_done(acc_done),
      .flush_req(flush_req), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
      .flush_en(fe_sync));
   wr_flush_ctrl #(.MODE(REL_VALID), .SYNC_ON_SOP(1'b1)) i_wr_flush_ctrl_val (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_done(acc_done),
      .flush_req(flush_req), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
      .flush_en(fe_val));
   wr_flush_ctrl #(.MODE(REL_SOP), .SYNC_ON_SOP(1'b1)) i_wr_flush_ctrl_sop (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_done(acc_done),
      .flush_req(flush_req), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
      .flush_en(fe_sop));
   wr_flush_ctrl #(.MODE(REL_SYNC), .SYNC_ON_SOP(1'b0)) i_wr_flush_ctrl_syw (
      .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_done(acc_done),
      .flush_req(flush_req), .st_valid(st_valid), .st_sop(st_sop), .st_sync(st_sync),
      .flush_en(fe_syw));

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: flush_en=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One clock with the given pulses; outputs sampled 1 ns after the edge
   task automatic cyc(input logic en, input logic wr, input logic req,
                      input logic v, input logic s, input logic y);
      acc_en = en; acc_wr = wr; flush_req = req;
      st_valid = v; st_sop = s; st_sync = y;
      @(posedge clk); #1;
      acc_en = 1'b0; acc_wr = 1'b0; flush_req = 1'b0;
      st_valid = 1'b0; st_sop = 1'b0; st_sync = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      cyc(0,0,0,0,0,0);
      cyc(0,0,0,0,0,0);
      rst = 1'b0;
      check("R1 sync", fe_sync, 1'b1);
      check("R1 val", fe_val, 1'b1);
      cyc(0,0,0,1,1,1);
      cyc(0,0,0,1,0,0);
      check("R1 val idle stream", fe_val, 1'b1);
      check("R1 sop idle stream", fe_sop, 1'b1);
      check("R11 syw idle stream", fe_syw, 1'b1);
   endtask

   task automatic t_read();
      acc_done = 1'b0;
      cyc(1,0,0,0,0,0);
      cyc(0,0,0,1,1,1);
      acc_done = 1'b1;
      check("R2 val", fe_val, 1'b1);
      check("R2 sync", fe_sync, 1'b1);
   endtask

   task automatic t_write_release();
      acc_done = 1'b0;
      cyc(1,1,0,1,1,1);   // boundary in the enable cycle does not count
      check("R3 val", fe_val, 1'b1);
      check("R3 sop", fe_sop, 1'b1);
      cyc(0,0,0,0,1,1);   // markers without valid
      check("R5 sop no valid", fe_sop, 1'b1);
      check("R7 syw no valid", fe_syw, 1'b1);
      check("R4 val no valid", fe_val, 1'b1);
      cyc(0,0,0,1,0,0);   // plain valid beat
      check("R4 val", fe_val, 1'b0);
      check("R5 sop valid only", fe_sop, 1'b1);
      check("R6 sync valid only", fe_sync, 1'b1);
      cyc(0,0,0,1,0,1);   // valid with sync wire
      check("R7 syw", fe_syw, 1'b0);
      check("R6 sync wire ignored", fe_sync, 1'b1);
      check("R5 sop sync ignored", fe_sop, 1'b1);
      cyc(0,0,0,1,1,0);   // valid with sop
      check("R5 sop", fe_sop, 1'b0);
      check("R6 sync via sop", fe_sync, 1'b0);
   endtask

   task automatic t_req_busy();
      acc_done = 1'b0;
      cyc(0,0,1,0,0,0);
      check("R9 sync", fe_sync, 1'b0);
      check("R9 val", fe_val, 1'b0);
   endtask

   task automatic t_req_and_en();
      acc_done = 1'b1;
      cyc(1,0,1,0,0,0);
      check("R10 sync", fe_sync, 1'b0);
      check("R10 sop", fe_sop, 1'b0);
   endtask

   task automatic t_req_ok();
      acc_done = 1'b1;
      cyc(0,0,1,0,0,0);
      check("R8 sync", fe_sync, 1'b1);
      check("R8 syw", fe_syw, 1'b1);
      cyc(0,0,0,1,1,1);
      check("R11 val unarmed", fe_val, 1'b1);
      acc_done = 1'b0;
      cyc(1,0,0,0,0,0);
      cyc(0,0,0,1,1,1);
      check("R2 after request", fe_val, 1'b1);
      cyc(1,1,0,0,0,0);
      check("R3 armed again", fe_val, 1'b1);
      cyc(0,0,0,1,0,0);
      check("R4 second release", fe_val, 1'b0);
      check("R5 second wait", fe_sop, 1'b1);
      acc_done = 1'b1;
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_read();
      t_write_release();
      t_req_busy();
      t_req_and_en();
      t_req_ok();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule